// File: doc/BRIEF.md
# Stack Pointer Register with Push/Pop Sequencing

This block is a 16-bit pointer register for an 8-bit processor whose address bus is 16 bits wide. It is stored as two byte halves that act together as a single up/down counter. Either half can be written from the 8-bit data bus. All sixteen bits can be taken from the address bus in one cycle. A clear control sets the whole register to zero in one cycle. The pointer value is always driven onto the address output, and its upper and lower bytes are also given as separate outputs for the data bus.

Push and pop strobes start a two-cycle access. The block applies the adjustment that goes before the access, presents the pointer with an "address valid" flag for exactly one cycle, and then applies the adjustment that goes after it. A direction input picks the convention. For a stack growing toward 0000h, push decrements before the access and pop increments after it. For a stack growing toward FFFFh, push increments before the access and pop decrements after it. So the pointer always marks the last item stored.

Top module: `ptr_stack_reg`

## Requirements
- R1: After reset, addr_o is 0000h and acc_valid_o is 0.
- R2: With ld_full_i high, addr_o equals addr_i after the next clock edge.
- R3: ld_hi_i writes data_i into bits 15:8 and ld_lo_i writes data_i into bits 7:0, each leaving the other byte unchanged. When both are high, both bytes take data_i.
- R4: zero_i sets all 16 bits to zero at the next edge.
- R5: inc_i adds one and dec_i subtracts one, modulo 65536 (FFFFh+1 = 0000h, 0000h-1 = FFFFh). When both are high, the value does not change.
- R6: When the access phase is not active, priority is ld_full_i, then zero_i, then the byte loads, then the push/pop strobes, then inc_i/dec_i. A lower-priority control that loses has no effect. push_i wins over pop_i.
- R7: With grow_up_i=0, a push strobe gives acc_valid_o=1 in the next cycle with addr_o = old-1, and the value stays old-1 afterwards.
- R8: With grow_up_i=0, a pop strobe gives acc_valid_o=1 in the next cycle with addr_o = old, and the value becomes old+1 on the following edge.
- R9: With grow_up_i=1, push pre-increments (valid at old+1, stays old+1) and pop post-decrements (valid at old, then old-1).
- R10: acc_valid_o is high for exactly one cycle per strobe. During that cycle every load, count and strobe input is ignored, and only the post-access adjustment is applied.
- R11: hi_o and lo_o always equal bits 15:8 and 7:0 of addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Data bus byte for half loads |
| addr_i | input | 16 | Address bus value for full loads |
| ld_full_i | input | 1 | Load all 16 bits from addr_i |
| zero_i | input | 1 | Clear the register |
| ld_hi_i | input | 1 | Load upper byte from data_i |
| ld_lo_i | input | 1 | Load lower byte from data_i |
| inc_i | input | 1 | Count up by one |
| dec_i | input | 1 | Count down by one |
| push_i | input | 1 | Start a store access |
| pop_i | input | 1 | Start a read access |
| grow_up_i | input | 1 | 1: stack grows toward FFFFh, 0: toward 0000h |
| addr_o | output | 16 | Pointer value driven to the address bus |
| hi_o | output | 8 | Upper pointer byte |
| lo_o | output | 8 | Lower pointer byte |
| acc_valid_o | output | 1 | Memory access phase, pointer is valid |

## Verification
A wrong internal pointer value appears directly on addr_o in the cycle after the edge that produced it, because the register drives the output with no logic in between. A sequencer stuck in the access phase, or one that skips it, shows on acc_valid_o one cycle after the strobe. A wrong or missing post-access adjustment shows on addr_o one cycle after that. The sweeps start accesses at the wrap boundaries 0000h and FFFFh in both directions, so an off-by-one or a wrong carry across the byte boundary shows within two cycles of the strobe.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
    localparam int BYTE_W = 8;
    localparam int NUM_HALVES = 2;
    localparam int PTR_W = BYTE_W * NUM_HALVES;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_ACC  = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       post_en;
        logic       post_up;
    } seq_regs_t;
endpackage

// File: rtl/ptr_stepper.sv
module ptr_stepper #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] plus_o,
    output logic [W-1:0] minus_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        plus_o  = val_i + ONE;
        minus_o = val_i - ONE;
    end
endmodule

// File: rtl/ptr_half.sv
module ptr_half #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] half_d,
    output logic [W-1:0] half_q
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) half_q <= '0;
        else         half_q <= half_d;
    end
endmodule

// File: rtl/ptr_sequencer.sv
module ptr_sequencer
    import ptr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic push_i,
    input  logic pop_i,
    input  logic grow_up_i,
    input  logic free_i,
    output logic start_o,
    output logic busy_o,
    output logic step_en_o,
    output logic step_up_o
);
    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        start_o   = 1'b0;
        step_en_o = 1'b0;
        step_up_o = 1'b0;
        busy_o    = (seq_q.state == SEQ_ACC);
        if (seq_q.state == SEQ_ACC) begin
            step_en_o   = seq_q.post_en;
            step_up_o   = seq_q.post_up;
            seq_d.state = SEQ_IDLE;
        end else if (free_i && (push_i || pop_i)) begin
            start_o     = 1'b1;
            seq_d.state = SEQ_ACC;
            if (push_i) begin
                step_en_o     = 1'b1;
                step_up_o     = grow_up_i;
                seq_d.post_en = 1'b0;
                seq_d.post_up = 1'b0;
            end else begin
                seq_d.post_en = 1'b1;
                seq_d.post_up = !grow_up_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '{state: SEQ_IDLE, post_en: 1'b0, post_up: 1'b0};
        else         seq_q <= seq_d;
    end
endmodule

// File: rtl/ptr_stack_reg.sv
module ptr_stack_reg
    import ptr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [BYTE_W-1:0] data_i,
    input  logic [PTR_W-1:0]  addr_i,
    input  logic              ld_full_i,
    input  logic              zero_i,
    input  logic              ld_hi_i,
    input  logic              ld_lo_i,
    input  logic              inc_i,
    input  logic              dec_i,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              grow_up_i,
    output logic [PTR_W-1:0]  addr_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic [BYTE_W-1:0] lo_o,
    output logic              acc_valid_o
);
    logic [PTR_W-1:0] ptr_d, ptr_q, ptr_plus, ptr_minus;
    logic [NUM_HALVES-1:0] byte_ld;
    logic seq_start, seq_busy, seq_step_en, seq_step_up, load_free;
    logic cnt_en, cnt_up;

    assign byte_ld   = {ld_hi_i, ld_lo_i};
    assign load_free = !(ld_full_i || zero_i || ld_hi_i || ld_lo_i);

    ptr_sequencer u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .grow_up_i (grow_up_i),
        .free_i    (load_free),
        .start_o   (seq_start),
        .busy_o    (seq_busy),
        .step_en_o (seq_step_en),
        .step_up_o (seq_step_up)
    );

    ptr_stepper #(.W(PTR_W)) u_step (
        .val_i   (ptr_q),
        .plus_o  (ptr_plus),
        .minus_o (ptr_minus)
    );

    always_comb begin
        ptr_d  = ptr_q;
        cnt_en = 1'b0;
        cnt_up = seq_step_up;
        if (seq_busy) begin
            cnt_en = seq_step_en;
        end else if (ld_full_i) begin
            ptr_d = addr_i;
        end else if (zero_i) begin
            ptr_d = '0;
        end else if (|byte_ld) begin
            for (int h = 0; h < NUM_HALVES; h++) begin
                if (byte_ld[h]) ptr_d[h*BYTE_W +: BYTE_W] = data_i;
            end
        end else if (seq_start) begin
            cnt_en = seq_step_en;
        end else if (inc_i ^ dec_i) begin
            cnt_en = 1'b1;
            cnt_up = inc_i;
        end
        if (cnt_en) ptr_d = cnt_up ? ptr_plus : ptr_minus;
    end

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        ptr_half #(.W(BYTE_W)) u_half (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .half_d (ptr_d[g*BYTE_W +: BYTE_W]),
            .half_q (ptr_q[g*BYTE_W +: BYTE_W])
        );
    end

    assign addr_o      = ptr_q;
    assign hi_o        = ptr_q[PTR_W-1 -: BYTE_W];
    assign lo_o        = ptr_q[BYTE_W-1:0];
    assign acc_valid_o = seq_busy;
endmodule

// File: rtl/ptr_stack_reg_sva.sv
module ptr_stack_reg_sva
    import ptr_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic [PTR_W-1:0] addr_i,
    input logic             ld_full_i,
    input logic             zero_i,
    input logic             ld_hi_i,
    input logic             ld_lo_i,
    input logic             inc_i,
    input logic             dec_i,
    input logic             push_i,
    input logic             pop_i,
    input logic             grow_up_i,
    input logic [PTR_W-1:0] addr_o,
    input logic             acc_valid_o
);
    logic any_ld;
    assign any_ld = ld_full_i || zero_i || ld_hi_i || ld_lo_i;

    a_r2_full_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_full_i && !acc_valid_o) |=> (addr_o == $past(addr_i)));

    a_r4_zero_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (zero_i && !ld_full_i && !acc_valid_o) |=> (addr_o == '0));

    a_r10_one_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_valid_o |=> !acc_valid_o);

    a_r5_inc_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !dec_i && !any_ld && !push_i && !pop_i && !acc_valid_o)
        |=> (addr_o == $past(addr_o) + 16'd1));

    a_r7_push_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !grow_up_i && !any_ld && !acc_valid_o)
        |=> (acc_valid_o && addr_o == $past(addr_o) - 16'd1));

    a_r9_push_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && grow_up_i && !any_ld && !acc_valid_o)
        |=> (acc_valid_o && addr_o == $past(addr_o) + 16'd1));
endmodule

bind ptr_stack_reg ptr_stack_reg_sva u_sva (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .ld_full_i   (ld_full_i),
    .zero_i      (zero_i),
    .ld_hi_i     (ld_hi_i),
    .ld_lo_i     (ld_lo_i),
    .inc_i       (inc_i),
    .dec_i       (dec_i),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .grow_up_i   (grow_up_i),
    .addr_o      (addr_o),
    .acc_valid_o (acc_valid_o)
);

// File: tb/ptr_stack_reg_tb_top.sv
`timescale 1ns/1ps
module ptr_stack_reg_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  data;
    logic [15:0] addr_in;
    logic ld_full, zero, ld_hi, ld_lo, inc, dec, push, pop, grow_up;
    logic [15:0] addr_out;
    logic [7:0]  hi, lo;
    logic valid;
    int checks = 0;
    int fails = 0;
    logic [15:0] starts [6] = '{16'h0000, 16'h0001, 16'h00FF, 16'h8000, 16'hFFFE, 16'hFFFF};

    always #5 clk = ~clk;

    ptr_stack_reg dut_i (
        .clk_i(clk), .rst_ni(rst_n), .data_i(data), .addr_i(addr_in),
        .ld_full_i(ld_full), .zero_i(zero), .ld_hi_i(ld_hi), .ld_lo_i(ld_lo),
        .inc_i(inc), .dec_i(dec), .push_i(push), .pop_i(pop), .grow_up_i(grow_up),
        .addr_o(addr_out), .hi_o(hi), .lo_o(lo), .acc_valid_o(valid)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        ld_full = 0; zero = 0; ld_hi = 0; ld_lo = 0;
        inc = 0; dec = 0; push = 0; pop = 0;
    endtask

    task automatic load16(input logic [15:0] v);
        ld_full = 1; addr_in = v; cyc(); ld_full = 0;
        chk("R2", addr_out, v);
        chk("R11", {hi, lo}, v);
    endtask

    // Push or pop; during the valid cycle every other control is driven (R10).
    task automatic access(input logic up, input logic is_push, input logic [15:0] s);
        logic [15:0] mid, fin;
        load16(s);
        if (!up) begin
            mid = is_push ? s - 16'd1 : s;
            fin = is_push ? s - 16'd1 : s + 16'd1;
        end else begin
            mid = is_push ? s + 16'd1 : s;
            fin = is_push ? s + 16'd1 : s - 16'd1;
        end
        grow_up = up; push = is_push; pop = !is_push;
        cyc();
        chk(up ? "R9 valid" : (is_push ? "R7 valid" : "R8 valid"), {15'd0, valid}, 16'd1);
        chk(up ? "R9 addr" : (is_push ? "R7 addr" : "R8 addr"), addr_out, mid);
        ld_full = 1; addr_in = 16'h5A5A; zero = 1; ld_hi = 1; inc = 1;
        grow_up = !up;
        cyc();
        idle_in();
        chk("R10 valid drop", {15'd0, valid}, 16'd0);
        chk(up ? "R9 final" : (is_push ? "R7 final" : "R8 final"), addr_out, fin);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog got=hang exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle_in(); data = 0; addr_in = 0; grow_up = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 addr", addr_out, 16'h0000);
        chk("R1 valid", {15'd0, valid}, 16'd0);
        rst_n = 1;
        cyc();

        // R2 sweep of walking-one patterns
        for (int b = 0; b < 16; b++) load16(16'h1 << b);
        load16(16'hFFFF);

        // R3 byte loads
        for (int v = 0; v < 256; v += 17) begin
            load16(16'hA5C3);
            data = v[7:0]; ld_hi = 1; cyc(); ld_hi = 0;
            chk("R3 hi", addr_out, {v[7:0], 8'hC3});
            data = ~v[7:0]; ld_lo = 1; cyc(); ld_lo = 0;
            chk("R3 lo", addr_out, {v[7:0], ~v[7:0]});
            chk("R11", {hi, lo}, addr_out);
        end
        data = 8'h3C; ld_hi = 1; ld_lo = 1; cyc(); idle_in();
        chk("R3 both", addr_out, 16'h3C3C);

        // R4 clear
        zero = 1; cyc(); zero = 0;
        chk("R4", addr_out, 16'h0000);

        // R5 counting with wraps
        for (int i = 0; i < 6; i++) begin
            load16(starts[i]);
            inc = 1; cyc(); inc = 0;
            chk("R5 inc", addr_out, starts[i] + 16'd1);
            dec = 1; cyc(); cyc(); dec = 0;
            chk("R5 dec", addr_out, starts[i] - 16'd1);
            inc = 1; dec = 1; cyc(); idle_in();
            chk("R5 both", addr_out, starts[i] - 16'd1);
        end

        // R6 priority
        load16(16'h1234);
        addr_in = 16'hBEEF; ld_full = 1; zero = 1; ld_hi = 1; push = 1; inc = 1; data = 8'h77;
        cyc(); idle_in();
        chk("R6 full wins", addr_out, 16'hBEEF);
        chk("R6 no access", {15'd0, valid}, 16'd0);
        zero = 1; ld_lo = 1; pop = 1; cyc(); idle_in();
        chk("R6 zero wins", addr_out, 16'h0000);
        chk("R6 no access", {15'd0, valid}, 16'd0);
        data = 8'h42; ld_hi = 1; push = 1; dec = 1; cyc(); idle_in();
        chk("R6 byte wins", addr_out, 16'h4200);
        chk("R6 no access", {15'd0, valid}, 16'd0);
        grow_up = 0; push = 1; pop = 1; inc = 1; cyc(); idle_in();
        chk("R6 push over pop", addr_out, 16'h41FF);
        chk("R6 strobe valid", {15'd0, valid}, 16'd1);
        cyc();
        chk("R6 push final", addr_out, 16'h41FF);

        // R7 R8 R9 sweeps over boundaries, both directions
        for (int d = 0; d < 2; d++)
            for (int p = 0; p < 2; p++)
                for (int i = 0; i < 6; i++)
                    access(d[0], p[0], starts[i]);

        // back-to-back strobes: second starts only after valid cycle ends
        load16(16'h0100); grow_up = 0; push = 1;
        cyc();
        chk("R10 b2b valid", {15'd0, valid}, 16'd1);
        cyc();
        chk("R10 b2b gap", {15'd0, valid}, 16'd0);
        cyc(); push = 0;
        chk("R7 b2b addr", addr_out, 16'h00FE);
        cyc();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule